// File: doc/BRIEF.md
# Coin Accumulating Vend Controller

This block counts coins from a single slot that takes nickels and dimes. When the deposited credit reaches the price of 15 cents, it drives a release signal. Credit is held as a small Moore state machine with four levels: 0, 5, 10 and 15 cents. The machine gives no change. Any coin that would carry the credit past the price is absorbed, and the credit stops at 15 cents.

Once the price is reached, the release signal stays asserted, whatever the coin inputs do, until the machine is reset. Coin inputs must already be clean pulses, one clock cycle long per coin and synchronous to the clock. A build parameter picks how the credit is stored: a binary counter or one flip-flop per credit level. The two forms behave the same at the ports.

Top module: `vend_ctrl`

## Requirements
- R1: While reset is active, and on the first cycle after it is released, open_o is 0 and the credit is 0 cents.
- R2: A nickel pulse (nickel_i=1, dime_i=0) adds 5 cents to the credit.
- R3: In a cycle with neither coin input high, the credit and open_o keep their values.
- R4: A dime pulse adds 10 cents. The credit saturates at 15 cents, so a dime at 10 cents also gives 15 cents, with no change.
- R5: open_o is 1 exactly when the credit is 15 cents. Once it is 1, it stays 1 under any coin inputs until reset.
- R6: When nickel_i and dime_i are high in the same cycle, the dime is counted and the nickel is ignored.
- R7: open_o is a registered Moore output. A coin sampled at a rising clock edge affects open_o only after that edge, never earlier in the same cycle.
- R8: The one-hot build (ONE_HOT=1) and the binary build (ONE_HOT=0) give the same open_o for every input sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; clears credit to 0 |
| nickel_i | input | 1 | One-cycle pulse per nickel inserted |
| dime_i | input | 1 | One-cycle pulse per dime inserted |
| open_o | output | 1 | Release mechanism drive; high at 15 cents credit |

## Verification
The bench tries every sequence of one to four coin cycles, drawn from idle, nickel, dime and both-at-once, against the binary and one-hot builds side by side. This covers the paying orders: three nickels, nickel then dime, dime then nickel, and two dimes. Sequences that pay too much show that credit saturates instead of wrapping. Coin cycles after the price show that the output stays latched. Cycles with both coin inputs high separate dime-priority from nickel-priority and from adding both coins. A check just before each clock edge separates a registered output from a combinational one.

// File: rtl/vend_pkg.sv
package vend_pkg;
  // coin credit in units of one nickel
  localparam int unsigned NICKEL_U = 1;
  localparam int unsigned DIME_U   = 2;
  localparam int unsigned PRICE_U  = 3;
  localparam int unsigned ADD_W    = $clog2(DIME_U + 1);

  typedef enum logic [1:0] {
    COIN_NONE   = 2'd0,
    COIN_NICKEL = 2'd1,
    COIN_DIME   = 2'd2
  } coin_e;
endpackage

// File: rtl/vend_coin_sel.sv
module vend_coin_sel
  import vend_pkg::*;
#(
  parameter int unsigned AW = ADD_W
) (
  input  logic          nickel_i,
  input  logic          dime_i,
  output coin_e         coin_o,
  output logic [AW-1:0] add_o
);
  // dime has priority over nickel
  always_comb begin
    if (dime_i)        coin_o = COIN_DIME;
    else if (nickel_i) coin_o = COIN_NICKEL;
    else               coin_o = COIN_NONE;
  end

  always_comb begin
    unique case (coin_o)
      COIN_DIME:   add_o = AW'(DIME_U);
      COIN_NICKEL: add_o = AW'(NICKEL_U);
      default:     add_o = '0;
    endcase
  end
endmodule

// File: rtl/vend_credit_bin.sv
module vend_credit_bin #(
  parameter int unsigned PRICE = 3,
  parameter int unsigned AW    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] add_i,
  output logic          paid_o
);
  localparam int unsigned CW = $clog2(PRICE + 1);
  localparam int unsigned SW = (CW > AW ? CW : AW) + 1;

  logic [CW-1:0] credit_q, credit_d;
  logic [SW-1:0] sum;

  assign sum = SW'(credit_q) + SW'(add_i);

  // saturate at price; price level is therefore absorbing
  always_comb begin
    if (sum >= SW'(PRICE)) credit_d = CW'(PRICE);
    else                   credit_d = sum[CW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) credit_q <= '0;
    else         credit_q <= credit_d;
  end

  assign paid_o = (credit_q == CW'(PRICE));
endmodule

// File: rtl/vend_credit_onehot.sv
module vend_credit_onehot #(
  parameter int unsigned PRICE = 3,
  parameter int unsigned AW    = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] add_i,
  output logic          paid_o
);
  localparam int unsigned NS = PRICE + 1;

  logic [NS-1:0] state_q, state_d;

  always_comb begin
    state_d = '0;
    for (int i = 0; i < NS; i++) begin
      int tgt;
      tgt = i + int'(add_i);
      if (tgt > int'(PRICE)) tgt = int'(PRICE);
      if (state_q[i]) state_d[tgt] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= NS'(1);
    else         state_q <= state_d;
  end

  assign paid_o = state_q[PRICE];
endmodule

// File: rtl/vend_ctrl.sv
module vend_ctrl
  import vend_pkg::*;
#(
  parameter bit ONE_HOT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic nickel_i,
  input  logic dime_i,
  output logic open_o
);
  coin_e            coin;
  logic [ADD_W-1:0] add;

  vend_coin_sel #(.AW(ADD_W)) u_sel (
    .nickel_i(nickel_i),
    .dime_i  (dime_i),
    .coin_o  (coin),
    .add_o   (add)
  );

  if (ONE_HOT) begin : g_oh
    vend_credit_onehot #(.PRICE(PRICE_U), .AW(ADD_W)) u_credit (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .add_i (add),
      .paid_o(open_o)
    );
  end else begin : g_bin
    vend_credit_bin #(.PRICE(PRICE_U), .AW(ADD_W)) u_credit (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .add_i (add),
      .paid_o(open_o)
    );
  end
endmodule

// File: rtl/vend_ctrl_chk.sv
module vend_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic nickel_i,
  input logic dime_i,
  input logic open_o
);
  AST_OPEN_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_o |=> open_o); // R5

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!nickel_i && !dime_i) |=> $stable(open_o)); // R3

  AST_OPEN_NEEDS_COIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(open_o) |-> $past(nickel_i || dime_i)); // R7

  AST_NO_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$fell(open_o)); // R5
endmodule

bind vend_ctrl vend_ctrl_chk u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .nickel_i(nickel_i),
  .dime_i  (dime_i),
  .open_o  (open_o)
);

// File: tb/vend_ctrl_test.sv
`timescale 1ns/1ps
module vend_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic nickel = 1'b0;
  logic dime = 1'b0;
  logic open_bin, open_oh;

  int total = 0;
  int bad = 0;
  int credit = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  vend_ctrl #(.ONE_HOT(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .nickel_i(nickel), .dime_i(dime), .open_o(open_bin)
  );
  vend_ctrl #(.ONE_HOT(1'b1)) uut_oh (
    .clk_i(clk), .rst_ni(rst_n), .nickel_i(nickel), .dime_i(dime), .open_o(open_oh)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: open=%0b expected=%0b credit=%0d", tag, act, exp, credit);
    end
  endtask

  task automatic check_both(input string tag, input logic exp);
    check(tag, open_bin, exp);
    check({tag, "/R8"}, open_oh, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    nickel = 1'b0; dime = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    check_both("R1", 1'b0);
    rst_n = 1'b1;
    credit = 0;
    @(negedge clk);
    check_both("R1", 1'b0);
  endtask

  // called at a negedge; leaves time at the next negedge
  task automatic step(input bit n, input bit d);
    string tag;
    logic prev;
    prev = (credit == 15);
    nickel = n; dime = d;
    #1;
    check_both("R7", prev);
    if (credit == 15)  tag = "R5";
    else if (n && d)   tag = "R6";
    else if (d)        tag = "R4";
    else if (n)        tag = "R2";
    else               tag = "R3";
    credit = credit + (d ? 10 : (n ? 5 : 0));
    if (credit > 15) credit = 15;
    @(negedge clk);
    check_both(tag, credit == 15);
  endtask

  task automatic idle_tail();
    step(1'b0, 1'b0);
    nickel = 1'b0; dime = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: open=%0b expected=done", open_bin);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    do_reset();
    // directed paying orders
    step(1, 0); step(1, 0); step(1, 0); idle_tail();  // R2 three nickels
    do_reset();
    step(1, 0); step(0, 1); idle_tail();              // R4 nickel then dime
    do_reset();
    step(0, 1); step(1, 0); idle_tail();              // R4 dime then nickel
    do_reset();
    step(0, 1); step(0, 1); step(0, 1); idle_tail();  // R4 two dimes, overpay, R5 hold
    do_reset();
    step(1, 1); step(1, 0); idle_tail();              // R6 both counts as dime
    // reset clears a latched open
    do_reset();
    check_both("R1", 1'b0);

    // exhaustive sweep: lengths 1..4, codes bit0 nickel, bit1 dime
    for (int len = 1; len <= 4; len++) begin
      for (int idx = 0; idx < (1 << (2 * len)); idx++) begin
        do_reset();
        for (int k = 0; k < len; k++) begin
          int code;
          code = (idx >> (2 * k)) & 3;
          step(code[0], code[1]);
        end
        idle_tail();
      end
    end

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule